// File: doc/BRIEF.md
# Serial Read-Data Sampling Delay Calibrator

This block chooses the sampling delay applied to the read-data input of a serial power-management link. It sweeps four delay codes, from 0 up to 3, which stand for nominal delays of 0, 2, 4 and 6 ns. For each code it first places the code on its delay output. It then issues a single read of a fixed test register through a request/acknowledge port and compares the returned 16-bit word with the known pattern 0x5AA5. Each comparison fills one bit of a 4-bit pass mask.

When the sweep is over, the mask is reduced to a final code by a fixed policy. A single passing code is taken as it is. With two adjacent passes the code at the edge of the delay range is preferred. With three passes the middle code is taken, and with four passes the lower of the two middle codes. A mask with no passes, or with a gap in it, is reported as an error.

Each read waits for its acknowledge for a bounded number of cycles. A read that times out counts as a fail for that code. The serial engine that carries out the read and the delay line itself sit outside this block.

Top module: `sidly_cal`

## Requirements
- R1: After reset, `done`, `err` and `rd_req` are low, `dly_code` is 0 and `pass_mask` is 0.
- R2: A `start` pulse while idle sweeps the codes 0, 1, 2 and 3 in that order. Each code is present on `dly_code` before and throughout its read. While `rd_req` is high, `rd_addr` equals `TEST_ADDR`, which defaults to 0xBC0A.
- R3: The read for code i passes only if it is acknowledged with `rd_data` equal to `PATTERN` (0x5AA5). A pass sets `pass_mask` bit i, and any other word leaves that bit clear. `start` clears the mask.
- R4: `rd_req` stays high until `rd_ack`. An acknowledge that arrives at most `TMO`-1 cycles after the first request cycle (default `TMO` = 16) is accepted. Without one, the request drops after `TMO` cycles, the code counts as failed and the sweep moves on.
- R5: When exactly one bit of the mask is set, that code becomes the final `dly_code`.
- R6: With two adjacent passes, mask 4'b0011 gives code 0, 4'b0110 gives code 1 and 4'b1100 gives code 3.
- R7: With three passes, mask 4'b0111 gives code 1 and 4'b1110 gives code 2. Mask 4'b1111 gives code 1.
- R8: Every other mask, including 4'b0000 and any mask with a gap, raises `err`. In that case `dly_code` keeps the last swept code, 3. `err` stays high until the next `start`, which clears it.
- R9: `done` is a one-cycle pulse at the end of each sweep. From that cycle on, `dly_code` holds its final value until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration sweep (ignored while busy) |
| done | output | 1 | One-cycle end-of-sweep pulse |
| err | output | 1 | No usable delay code was found |
| dly_code | output | 2 | Delay code driven to the delay line |
| rd_addr | output | AW | Address of the test register |
| rd_req | output | 1 | Read request, held until acknowledge or timeout |
| rd_ack | input | 1 | Read acknowledge with valid data |
| rd_data | input | DW | Read data, sampled together with `rd_ack` |
| pass_mask | output | 4 | Per-code pass results, bit i for code i |

## Verification
A wrong sweep index shows up at the very next rise of `rd_req`, because `dly_code` no longer matches the code the bench expects for that read. A faulty pass decision or timeout count shows up in `pass_mask` one cycle after the acknowledge, or after the timeout. A wrong choice policy or a wrong error flag shows up in the `done` cycle. The bench covers all sixteen masks, both sides of the timeout boundary and the persistence of the error flag, so every one of these states reaches the ports within one sweep.

// File: rtl/sidly_cal.sv
module sidly_cal #(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] TEST_ADDR = 'hBC0A,
  parameter logic [DW-1:0] PATTERN   = 'h5AA5,
  parameter int            TMO       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          err,
  output logic [1:0]    dly_code,
  output logic [AW-1:0] rd_addr,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic [3:0]    pass_mask
);
  localparam int CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO - 1);

  typedef enum logic [1:0] {S_IDLE, S_SET, S_READ, S_PICK} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] pick;
  logic pick_ok;
  logic give_up;

  assign rd_req  = (st == S_READ);
  assign rd_addr = TEST_ADDR;
  assign give_up = (cnt == CNT_LAST);

  always_comb begin
    pick_ok = 1'b1;
    pick    = 2'd0;
    unique case (pass_mask)
      4'b0001, 4'b0011:                   pick = 2'd0;
      4'b0010, 4'b0110, 4'b0111, 4'b1111: pick = 2'd1;
      4'b0100, 4'b1110:                   pick = 2'd2;
      4'b1000, 4'b1100:                   pick = 2'd3;
      default:                            pick_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      dly_code  <= 2'd0;
      pass_mask <= 4'd0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pass_mask <= 4'd0;
          dly_code  <= 2'd0;
          err       <= 1'b0;
          st        <= S_SET;
        end
        S_SET: begin
          cnt <= '0;
          st  <= S_READ;
        end
        S_READ: begin
          if (rd_ack || give_up) begin
            if (rd_ack && rd_data == PATTERN) pass_mask[dly_code] <= 1'b1;
            if (dly_code == 2'd3) st <= S_PICK;
            else begin
              dly_code <= dly_code + 2'd1;
              st       <= S_SET;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          done <= 1'b1;
          st   <= S_IDLE;
          if (pick_ok) dly_code <= pick;
          else         err      <= 1'b1;
        end
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !give_up) |=> rd_req);

  // R4
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST);

  // R2
  code_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !give_up) |=> $stable(dly_code));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> $stable(dly_code));
endmodule

// File: tb/tb_sidly_cal.sv
module tb_sidly_cal;
  localparam int TMO = 16;
  localparam int NEVER = 999;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, err, rd_req, rd_ack = 1'b0;
  logic [1:0] dly_code;
  logic [15:0] rd_addr, rd_data = 16'h0;
  logic [3:0] pass_mask;

  int n_chk = 0, n_fail = 0;
  int lat_cfg [4];
  bit good_cfg [4];
  int exp_idx = 0;

  always #4 clk = ~clk;

  sidly_cal dut (.clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .dly_code(dly_code), .rd_addr(rd_addr), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .pass_mask(pass_mask));

  task automatic ck(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [3:0] m);
    case (m)
      4'b0001, 4'b0011: return 0;
      4'b0010, 4'b0110, 4'b0111, 4'b1111: return 1;
      4'b0100, 4'b1110: return 2;
      4'b1000, 4'b1100: return 3;
      default: return -1;
    endcase
  endfunction

  initial begin : responder
    int wcnt;
    bit prev_req;
    wcnt = 0;
    prev_req = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_req && !prev_req) begin
        ck(dly_code == 2'(exp_idx), "R2 sweep code", dly_code, exp_idx);
        ck(rd_addr == 16'hBC0A, "R2 address", rd_addr, 16'hBC0A);
        exp_idx++;
      end
      prev_req = rd_req;
      if (rd_ack) begin
        rd_ack = 1'b0;
        wcnt = 0;
      end else if (rd_req) begin
        if (wcnt == lat_cfg[dly_code]) begin
          rd_ack = 1'b1;
          rd_data = good_cfg[dly_code] ? 16'h5AA5 : (16'h5AA5 ^ 16'(1 << $urandom_range(0, 15)));
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  task automatic sweep(input string tag);
    logic [3:0] em;
    int ec, waited;
    em = 4'd0;
    for (int i = 0; i < 4; i++)
      if (good_cfg[i] && lat_cfg[i] <= TMO - 1) em[i] = 1'b1;
    ec = exp_code(em);
    exp_idx = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    ck(err == 1'b0, "R8 start clears err", err, 0);
    waited = 0;
    while (!done && waited < 3000) begin @(negedge clk); waited++; end
    ck(done == 1'b1, {"R9 done seen ", tag}, done, 1);
    ck(pass_mask == em, {"R3 R4 mask ", tag}, pass_mask, em);
    if (ec < 0) begin
      ck(err == 1'b1, {"R8 err ", tag}, err, 1);
      ck(dly_code == 2'd3, {"R8 code kept ", tag}, dly_code, 3);
    end else begin
      ck(err == 1'b0, {"R5 R6 R7 no err ", tag}, err, 0);
      ck(dly_code == 2'(ec), {"R5 R6 R7 code ", tag}, dly_code, ec);
    end
    @(negedge clk);
    ck(done == 1'b0, "R9 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    ck(dly_code == ((ec < 0) ? 2'd3 : 2'(ec)), "R9 code held", dly_code, ec);
    ck(err == (ec < 0), "R8 err held", err, ec < 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin lat_cfg[i] = 0; good_cfg[i] = 1'b1; end
    repeat (3) @(negedge clk);
    ck(!done && !err && !rd_req && dly_code == 0 && pass_mask == 0, "R1 reset state",
       {done, err, rd_req, dly_code, pass_mask}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ck(dly_code == 0 && pass_mask == 0 && !rd_req, "R1 after release", dly_code, 0);
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 4; i++) begin
        good_cfg[i] = m[i];
        lat_cfg[i] = $urandom_range(0, 4);
      end
      sweep($sformatf("mask %0d", m));
    end
    for (int i = 0; i < 4; i++) begin good_cfg[i] = 1'b1; lat_cfg[i] = 2; end
    lat_cfg[0] = TMO - 1;
    lat_cfg[3] = TMO;
    sweep("R4 boundary 0111");
    lat_cfg[3] = NEVER; lat_cfg[1] = NEVER;
    sweep("R4 no ack gap");
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < 4; i++) begin
        good_cfg[i] = ($urandom_range(0, 3) != 0);
        case ($urandom_range(0, 7))
          0: lat_cfg[i] = NEVER;
          1: lat_cfg[i] = TMO;
          2: lat_cfg[i] = TMO - 1;
          default: lat_cfg[i] = $urandom_range(0, 6);
        endcase
      end
      sweep("random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule